// File: doc/BRIEF.md
# Single-line serial command master

This block is the master side of a clocked serial link that has one shared data line. Software loads a command word and up to two 32-bit words of command data through a small write window. On a valid command the engine does the following, in order:

- It clocks out a start slot and then the command bits. Every bit is driven inverted onto a data line that idles high.
- It sends a fixed echo gap.
- It releases the line and hunts for the slave's start bit, giving up after a bounded number of clocks.
- It captures a 4-bit identity/tag field, an optional response word and a 4-bit check field.

Each result is held in an output register, together with a status code. A fixed post-command gap of idle-high clocks then closes the transaction before the next command can be accepted.

The serial clock idles high. Each bit slot holds the clock high for `DIV` system clocks while the data is set up, then low for `DIV` system clocks. Incoming bits are sampled on the last system clock of the low phase. The engine does not compute or check the 4-bit check field; it only captures it.

Top module: `sline_master`

## Requirements
- R1: After reset the outputs are as follows: `scl_o`=1, `sda_o`=1, `sda_oe_o`=1, `status_o`=0x00, `tag_o`=0, `crc_o`=0, `rsp_o`=0xFFFFFFFF, `busy_o`=0.
- R2: The command word is written with `wr_sel`=0 and has these fields: bits [7:0] hold the code, bits [15:8] the command length in bits (0..64), bits [23:16] the response length in bits (0..32), and bits [31:24] are unused. One cycle after code 0x01 is written, `status_o` reads 0x01 (sending), the code byte of `cmd_o` reads 0, and `busy_o` is high.
- R3: Code 0x02 sets `status_o` to 0x02 one cycle after it is written, with no serial clock pulse. Any code other than 0x00, 0x01 or 0x02 sets `status_o` to 0x80, also with no clock pulse.
- R4: The first bit slot drives the line low. Each following slot carries one command bit, taken MSB first from the 64-bit value {data word 0, data word 1} and driven inverted. Data word 0 is written with `wr_sel`=1 and data word 1 with `wr_sel`=2. Each slot is one clock pulse, high then low.
- R5: After the command bits, 16 slots are sent with the line high. `sda_oe_o` then falls for the receive phase.
- R6: The line is sampled once per slot for at most 1000 slots, waiting for a low level. If no low level arrives, `status_o` becomes 0x82, no fields are captured, and the post-command gap follows.
- R7: After the start bit, 4 bits are captured, first-received most significant. They are stored inverted in `tag_o`.
- R8: Response bits are captured only when the stored tag has bits [2:0] equal to 0 and the response length is nonzero. That many bits are captured and stored inverted and right-aligned in `rsp_o`, with every unused upper bit reading 1. Otherwise `rsp_o` keeps its earlier value.
- R9: A 4-bit check field is always captured last and stored inverted in `crc_o`. Then `status_o` becomes 0x02.
- R10: Every transaction that reaches the line ends with 16 slots of the line driven high. `busy_o` then falls. While `busy_o` is low, the clock and data lines stay high and are driven.
- R11: Writes made while `busy_o` is high leave the command word and data words unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 command, 1 data word 0, 2 data word 1 |
| wr_data | input | 32 | Write data |
| cmd_o | output | 32 | Command word as currently held |
| status_o | output | 8 | Status code |
| tag_o | output | 4 | Captured identity/tag field |
| crc_o | output | 4 | Captured check field |
| rsp_o | output | 32 | Captured response data, right-aligned |
| busy_o | output | 1 | Command pending or transaction in progress |
| scl_o | output | 1 | Serial clock, idle high |
| sda_o | output | 1 | Data line drive value |
| sda_oe_o | output | 1 | Data line drive enable, also transceiver direction (1 = out) |
| sda_i | input | 1 | Data line input |

## Verification
The assertions check the following on every cycle:
- the idle line state whenever the engine is not busy;
- that the line is released only inside a transaction;
- the one-cycle reaction to the start, break and invalid codes;
- the stability of the command word during a transaction.

Only the bench's slave model can show the rest. It shows the exact bit stream and its inversion, the start-bit hunt up to its last permitted slot and the timeout beyond it, and the tag-gated capture of response data with its ones-filled upper bits. It also shows the total clock count of each transaction.

// File: rtl/sline_master.sv
module sline_master #(
  parameter int DIV       = 2,
  parameter int ECHO_CLKS = 16,
  parameter int POST_CLKS = 16,
  parameter int WAIT_MAX  = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] cmd_o,
  output logic [7:0]  status_o,
  output logic [3:0]  tag_o,
  output logic [3:0]  crc_o,
  output logic [31:0] rsp_o,
  output logic        busy_o,
  output logic        scl_o,
  output logic        sda_o,
  output logic        sda_oe_o,
  input  logic        sda_i
);
  localparam int CW   = (2 * DIV > 2) ? $clog2(2 * DIV) : 1;
  localparam int BMAX = (WAIT_MAX > 66) ? WAIT_MAX : 66;
  localparam int BW   = $clog2(BMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_TX, S_ECHO, S_WAIT, S_TAG, S_DATA, S_CRC, S_POST} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bcnt, lim;
  logic [64:0] tsh;
  logic [31:0] rx, d0_q, d1_q, cmd_q, rsp_q;
  logic [7:0]  stat_q;
  logic [3:0]  tag_q, crc_q;
  logic [6:0]  clen_c;
  logic [5:0]  rlen_c;

  assign clen_c = (cmd_q[15:8] > 8'd64) ? 7'd64 : cmd_q[14:8];
  assign rlen_c = (cmd_q[23:16] > 8'd32) ? 6'd32 : cmd_q[21:16];

  wire        slot_end = (cnt == CW'(2 * DIV - 1));
  wire        last     = slot_end && (bcnt == lim - BW'(1));
  wire [31:0] rx_next  = {rx[30:0], sda_i};
  wire        rx_phase = (st == S_WAIT) || (st == S_TAG) || (st == S_DATA) || (st == S_CRC);

  always_comb begin
    case (st)
      S_TX:           lim = BW'(clen_c) + BW'(1);
      S_ECHO:         lim = BW'(ECHO_CLKS);
      S_WAIT:         lim = BW'(WAIT_MAX);
      S_TAG, S_CRC:   lim = BW'(4);
      S_DATA:         lim = BW'(rlen_c);
      S_POST:         lim = BW'(POST_CLKS);
      default:        lim = BW'(1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bcnt <= '0; tsh <= '0; rx <= '0;
      d0_q <= '0; d1_q <= '0; cmd_q <= '0; rsp_q <= '1;
      stat_q <= 8'h00; tag_q <= '0; crc_q <= '0;
    end else begin
      if (wr_en && !busy_o) begin
        case (wr_sel)
          2'd0:    cmd_q <= wr_data;
          2'd1:    d0_q  <= wr_data;
          2'd2:    d1_q  <= wr_data;
          default: ;
        endcase
      end
      if (st == S_IDLE) begin
        cnt  <= '0;
        bcnt <= '0;
        if (cmd_q[7:0] != 8'h00) begin
          cmd_q[7:0] <= 8'h00;
          case (cmd_q[7:0])
            8'h01: begin st <= S_TX; stat_q <= 8'h01; tsh <= {1'b1, d0_q, d1_q}; end
            8'h02: stat_q <= 8'h02;
            default: stat_q <= 8'h80;
          endcase
        end
      end else begin
        cnt <= slot_end ? '0 : cnt + CW'(1);
        if (slot_end) begin
          rx   <= rx_next;
          tsh  <= tsh << 1;
          bcnt <= last ? '0 : bcnt + BW'(1);
          case (st)
            S_TX:   if (last) st <= S_ECHO;
            S_ECHO: if (last) st <= S_WAIT;
            S_WAIT:
              if (!sda_i) begin
                st <= S_TAG; bcnt <= '0; rx <= '0;
              end else if (last) begin
                stat_q <= 8'h82; st <= S_POST;
              end
            S_TAG:
              if (last) begin
                tag_q <= ~rx_next[3:0];
                rx    <= '0;
                st    <= (rx_next[2:0] == 3'b111 && rlen_c != 6'd0) ? S_DATA : S_CRC;
              end
            S_DATA: if (last) begin rsp_q <= ~rx_next; rx <= '0; st <= S_CRC; end
            S_CRC:  if (last) begin crc_q <= ~rx_next[3:0]; stat_q <= 8'h02; st <= S_POST; end
            S_POST: if (last) st <= S_IDLE;
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  assign busy_o   = (st != S_IDLE) || (cmd_q[7:0] != 8'h00);
  assign scl_o    = !((st != S_IDLE) && (cnt >= CW'(DIV)));
  assign sda_oe_o = !rx_phase;
  assign sda_o    = (st == S_TX) ? ~tsh[64] : 1'b1;
  assign cmd_o    = cmd_q;
  assign status_o = stat_q;
  assign tag_o    = tag_q;
  assign crc_o    = crc_q;
  assign rsp_o    = rsp_q;
endmodule

// File: rtl/sline_master_chk.sv
module sline_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy_o,
  input logic [31:0] cmd_o,
  input logic [7:0]  status_o,
  input logic        scl_o,
  input logic        sda_o,
  input logic        sda_oe_o
);
  assert_idle_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (scl_o && sda_o && sda_oe_o));

  assert_release_in_txn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sda_oe_o |-> busy_o);

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o[7:0] == 8'h01) |=> (status_o == 8'h01 && cmd_o[7:0] == 8'h00 && busy_o));

  assert_break_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o[7:0] == 8'h02) |=> (status_o == 8'h02 && !busy_o));

  assert_bad_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o[7:0] > 8'h02) |=> (status_o == 8'h80));

  assert_cmd_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cmd_o[7:0] == 8'h00) |=> $stable(cmd_o));
endmodule

bind sline_master sline_master_chk u_chk (.*);

// File: tb/sline_master_tb.sv
module sline_master_tb;
  logic clk = 0, rst_n = 0, wr_en = 0, sda_i = 1;
  logic [1:0]  wr_sel = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] cmd_o, rsp_o;
  logic [7:0]  status_o;
  logic [3:0]  tag_o, crc_o;
  logic busy_o, scl_o, sda_o, sda_oe_o;

  int checks = 0, fails = 0, ecount = 0;
  logic [31:0] exp_rsp = 32'hFFFF_FFFF;
  logic [3:0]  exp_tag = 0, exp_crc = 0;

  sline_master u_dut (.*);

  always #4 clk = ~clk;
  always @(negedge scl_o) ecount++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  function automatic logic rbit(int k, int dly, logic [3:0] t, logic [31:0] v, int nd, logic [3:0] c);
    if (k < dly) return 1'b1;
    if (k == dly) return 1'b0;
    k = k - dly - 1;
    if (k < 4) return ~t[3-k];
    k = k - 4;
    if (k < nd) return ~v[nd-1-k];
    k = k - nd;
    if (k < 4) return ~c[3-k];
    return 1'b1;
  endfunction

  task automatic run(input int clen, input int rlen, input logic [31:0] d0, input logic [31:0] d1,
                     input int dly, input logic [3:0] t, input logic [31:0] v, input logic [3:0] c,
                     input bit tmo, input bit wbusy);
    logic [63:0] cat = {d0, d1};
    logic [31:0] cw = {8'h00, 8'(rlen), 8'(clen), 8'h01};
    int nd = (!tmo && t[2:0] == 3'b000 && rlen != 0) ? rlen : 0;
    int exp_edges;
    wr(2'd1, d0); wr(2'd2, d1);
    ecount = 0;
    wr(2'd0, cw);
    @(negedge clk);
    check(status_o == 8'h01 && cmd_o[7:0] == 8'h00 && busy_o, "R2 accept",
          {status_o, cmd_o[7:0], 15'd0, busy_o}, {8'h01, 8'h00, 15'd0, 1'b1});
    fork
      begin
        int bad4 = 0, bad5 = 0;
        for (int i = 0; i <= clen + 16; i++) begin
          logic e;
          @(negedge scl_o);
          e = (i == 0) ? 1'b0 : (i <= clen) ? ~cat[64-i] : 1'b1;
          if (sda_o !== e) begin
            if (i <= clen) bad4++; else bad5++;
          end
        end
        check(bad4 == 0, "R4 command bit stream", bad4, 0);
        check(bad5 == 0, "R5 echo gap high", bad5, 0);
        @(posedge scl_o);
        check(sda_oe_o == 1'b0, "R5 line released", {31'd0, sda_oe_o}, 0);
        if (!tmo) begin
          sda_i = rbit(0, dly, t, v, nd, c);
          for (int k = 1; k <= dly + 8 + nd; k++) begin
            @(posedge scl_o);
            sda_i = rbit(k, dly, t, v, nd, c);
          end
          @(posedge scl_o);
          sda_i = 1'b1;
        end
      end
      begin
        if (wbusy) begin
          repeat (50) @(negedge clk);
          wr(2'd0, 32'h00AB_CD05);
        end
      end
      begin
        @(negedge clk);
        while (busy_o) @(negedge clk);
      end
    join
    if (tmo) begin
      exp_edges = 1 + clen + 16 + 1000 + 16;
      check(status_o == 8'h82, "R6 timeout status", {24'd0, status_o}, 32'h82);
      check(tag_o == exp_tag && crc_o == exp_crc, "R6 no capture on timeout",
            {24'd0, tag_o, crc_o}, {24'd0, exp_tag, exp_crc});
    end else begin
      exp_edges = 1 + clen + 16 + (dly + 1) + 4 + nd + 4 + 16;
      exp_tag = t; exp_crc = c;
      if (nd != 0) exp_rsp = (nd == 32) ? v : (v | (32'hFFFF_FFFF << nd));
      check(tag_o == exp_tag, "R7 tag capture", {28'd0, tag_o}, {28'd0, exp_tag});
      check(rsp_o == exp_rsp, "R8 response data", rsp_o, exp_rsp);
      check(crc_o == exp_crc && status_o == 8'h02, "R9 check field and complete",
            {20'd0, crc_o, status_o}, {20'd0, exp_crc, 8'h02});
    end
    check(ecount == exp_edges, "R10 total clocks incl post gap", ecount, exp_edges);
    check(sda_oe_o && sda_o && scl_o, "R10 idle after txn", {29'd0, sda_oe_o, sda_o, scl_o}, 32'h7);
    if (wbusy) check(cmd_o == {cw[31:8], 8'h00}, "R11 write while busy ignored", cmd_o, {cw[31:8], 8'h00});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(scl_o && sda_o && sda_oe_o && !busy_o && status_o == 0 && tag_o == 0 && crc_o == 0,
          "R1 reset outputs", {scl_o, sda_o, sda_oe_o, busy_o, status_o}, {4'b1110, 8'h00});
    check(rsp_o == 32'hFFFF_FFFF, "R1 reset response", rsp_o, 32'hFFFF_FFFF);
    rst_n = 1;
    repeat (2) @(negedge clk);

    ecount = 0;
    wr(2'd0, 32'h0000_105A);
    @(negedge clk);
    check(status_o == 8'h80 && !busy_o, "R3 invalid code", {24'd0, status_o}, 32'h80);
    wr(2'd0, 32'h0000_2002);
    @(negedge clk);
    check(status_o == 8'h02 && !busy_o, "R3 break", {24'd0, status_o}, 32'h02);
    repeat (10) @(negedge clk);
    check(ecount == 0, "R3 no clock on break/invalid", ecount, 0);

    run(64, 32, 32'h8123_4567, 32'h89AB_CDEF, 3, 4'b1000, 32'hDEAD_BEEF, 4'hA, 0, 0);
    run(32, 8,  32'hF0F0_1234, 32'h0, 0, 4'b0000, 32'h0000_005C, 4'h3, 0, 0);
    run(0, 16,  32'h0, 32'h0, 5, 4'b0011, 32'h1234, 4'h6, 0, 1);
    run(12, 0,  32'hABC0_0000, 32'h0, 2, 4'b0000, 32'h0, 4'hF, 0, 0);
    run(40, 20, 32'h1357_9BDF, 32'h2468_0000, 999, 4'b1000, 32'h000A_BCDE, 4'h1, 0, 0);
    run(8, 12,  32'hA500_0000, 32'h0, 0, 4'h0, 32'h0, 4'h0, 1, 0);
    for (int n = 0; n < 12; n++) begin
      logic [3:0] t = 4'($urandom);
      if ($urandom_range(0, 1) == 1) t[2:0] = 3'b000;
      run($urandom_range(0, 64), $urandom_range(0, 32), $urandom, $urandom,
          $urandom_range(0, 30), t, $urandom, 4'($urandom), 0, (n == 5));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule